// File: doc/BRIEF.md
# Memory Field Extension Unit

This block widens the 12-bit address of a small word-addressed processor so that it can reach more than 4096 words. It keeps two small bank registers. The data bank register is used only for the operand access that follows an indirect pointer. The code bank register is used for every other access: instruction fetches, reads of the pointer word itself, and direct operand accesses. The selected bank number is placed above the 12-bit processor address to form the physical address.

Software selects a new data bank by storing a word whose top four bits are 1100 to the I/O address 0xFFF. The low bits of that word become the data bank. The code bank never changes directly. It takes a copy of the data bank on the clock edge at which a taken jump is signalled, so the first fetch at the jump target already uses the new bank. Any access to 0xFFF is steered to the I/O port and never to memory, whatever the bank registers hold.

Top module: `mfx_unit`

## Requirements
- R1: While `rst` is high at a clock edge, both bank registers are cleared to 0, so the first accesses after reset carry bank 0 in the upper address bits.
- R2: Accesses of kind fetch (`accKind`=0), pointer read (1) and direct operand (3) place the code bank above `cpuAddr` in `physAddr`.
- R3: An access of kind indirect operand (`accKind`=2) places the data bank above `cpuAddr` in `physAddr`.
- R4: A valid write (`accWrite`=1) of kind 2 or 3 to `cpuAddr`=0xFFF with `wrData[11:8]`=4'hC loads `wrData[FieldW-1:0]` into the data bank at that clock edge.
- R5: The data bank keeps its value after a write to 0xFFF whose top nibble is not 4'hC, after a write of a 0xCxx word to any other address, and after a read of 0xFFF.
- R6: When `jumpTaken` is high at a clock edge, the code bank takes the value the data bank held before that edge; the data bank itself is unchanged.
- R7: Without `jumpTaken` (including a conditional jump not taken), the code bank keeps its value even when the data bank changes.
- R8: A valid access with `cpuAddr`=0xFFF raises `ioSel` and keeps `memEn` low, for every bank value.
- R9: With `accValid` low, both `memEn` and `ioSel` are low; with `accValid` high and `cpuAddr` other than 0xFFF, `memEn` is high and `ioSel` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| accValid | input | 1 | An access is made this cycle |
| accKind | input | 2 | 0 fetch, 1 pointer read, 2 indirect operand, 3 direct operand |
| accWrite | input | 1 | The access is a store |
| cpuAddr | input | 12 | Processor word address |
| wrData | input | 12 | Store data bus |
| jumpTaken | input | 1 | A jump is taken this cycle |
| physAddr | output | FieldW+12 | Bank number above the processor address |
| memEn | output | 1 | Access goes to memory |
| ioSel | output | 1 | Access goes to the I/O port |

## Verification
The assertions take for granted that `jumpTaken` is never raised in the same cycle as a bank-setting store, since a processor cannot jump and store at once, and that `accWrite` is only raised with operand access kinds. The stimulus respects both: jumps are issued in cycles with no access or with a plain fetch, and stores are issued only as kind 2 or 3. Within that envelope the bench sweeps every pairing of data bank and code bank for the small default bank width, across all four access kinds and the I/O address.

// File: rtl/mfx_pkg.sv
package mfx_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_PTR   = 2'd1,
    ACC_IND   = 2'd2,
    ACC_DIR   = 2'd3
  } accKind_t;

  // strobes from the control to the bank datapath
  typedef struct packed {
    logic loadDf;
    logic copyIf;
    logic useDf;
    logic ioHit;
    logic memHit;
  } fieldCtl_t;
endpackage

// File: rtl/mfx_ctrl.sv
module mfx_ctrl
  import mfx_pkg::*;
#(
  parameter int WordW = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accValid,
  input  accKind_t         accKind,
  input  logic             accWrite,
  input  logic [WordW-1:0] cpuAddr,
  input  logic [WordW-1:0] wrData,
  input  logic             jumpTaken,
  output fieldCtl_t        ctl
);
  localparam int TagW = 4;
  localparam logic [WordW-1:0] IoAddr = '1;
  localparam logic [TagW-1:0] SetTag = 4'hC;

  logic isIo;
  logic isOperand;
  logic tagMatch;

  assign isIo      = (cpuAddr == IoAddr);
  assign isOperand = (accKind == ACC_IND) || (accKind == ACC_DIR);
  assign tagMatch  = (wrData[WordW-1 -: TagW] == SetTag);

  always_comb begin
    ctl        = '0;
    ctl.ioHit  = accValid && isIo;
    ctl.memHit = accValid && !isIo;
    ctl.useDf  = accValid && (accKind == ACC_IND);
    ctl.loadDf = accValid && accWrite && isOperand && isIo && tagMatch;
    ctl.copyIf = jumpTaken;
  end

  // R8: an I/O hit never reaches memory
  assert_io_not_mem_R8: assert property (@(posedge clk) disable iff (rst)
    ctl.ioHit |-> !ctl.memHit);

  // R9: nothing is selected without a valid access
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !accValid |-> (!ctl.ioHit && !ctl.memHit && !ctl.loadDf));

  // input assumption: no bank store while a jump is taken
  assert_no_jump_store_R6: assert property (@(posedge clk) disable iff (rst)
    ctl.copyIf |-> !ctl.loadDf);
endmodule

// File: rtl/mfx_datapath.sv
module mfx_datapath
  import mfx_pkg::*;
#(
  parameter int WordW  = 12,
  parameter int FieldW = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  fieldCtl_t               ctl,
  input  logic [WordW-1:0]        cpuAddr,
  input  logic [WordW-1:0]        wrData,
  output logic [FieldW+WordW-1:0] physAddr,
  output logic                    memEn,
  output logic                    ioSel
);
  logic [FieldW-1:0] dfReg;
  logic [FieldW-1:0] ifReg;
  logic [FieldW-1:0] bankSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      dfReg <= '0;
      ifReg <= '0;
    end else begin
      if (ctl.loadDf) dfReg <= wrData[FieldW-1:0];
      if (ctl.copyIf) ifReg <= dfReg;
    end
  end

  assign bankSel  = ctl.useDf ? dfReg : ifReg;
  assign physAddr = {bankSel, cpuAddr};
  assign memEn    = ctl.memHit;
  assign ioSel    = ctl.ioHit;

  // R1: reset leaves both banks at zero
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (dfReg == '0 && ifReg == '0));

  // R6: a taken jump moves the old data bank into the code bank
  assert_jump_copy_R6: assert property (@(posedge clk) disable iff (rst)
    ctl.copyIf |=> (ifReg == $past(dfReg)));

  // R7: without a jump the code bank holds
  assert_if_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !ctl.copyIf |=> $stable(ifReg));

  // R5: without a bank store the data bank holds
  assert_df_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !ctl.loadDf |=> $stable(dfReg));
endmodule

// File: rtl/mfx_unit.sv
module mfx_unit
  import mfx_pkg::*;
#(
  parameter int FieldW = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accValid,
  input  logic [1:0]         accKind,
  input  logic               accWrite,
  input  logic [11:0]        cpuAddr,
  input  logic [11:0]        wrData,
  input  logic               jumpTaken,
  output logic [FieldW+11:0] physAddr,
  output logic               memEn,
  output logic               ioSel
);
  localparam int WordW = 12;

  fieldCtl_t ctl;

  mfx_ctrl #(.WordW(WordW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .accValid  (accValid),
    .accKind   (accKind_t'(accKind)),
    .accWrite  (accWrite),
    .cpuAddr   (cpuAddr),
    .wrData    (wrData),
    .jumpTaken (jumpTaken),
    .ctl       (ctl)
  );

  mfx_datapath #(.WordW(WordW), .FieldW(FieldW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .cpuAddr  (cpuAddr),
    .wrData   (wrData),
    .physAddr (physAddr),
    .memEn    (memEn),
    .ioSel    (ioSel)
  );
endmodule

// File: tb/mfx_unit_tb.sv
module mfx_unit_tb;
  localparam int FieldW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic accValid = 1'b0;
  logic [1:0] accKind = 2'd0;
  logic accWrite = 1'b0;
  logic [11:0] cpuAddr = 12'd0;
  logic [11:0] wrData = 12'd0;
  logic jumpTaken = 1'b0;
  logic [FieldW+11:0] physAddr;
  logic memEn;
  logic ioSel;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [FieldW-1:0] mdf = '0;
  logic [FieldW-1:0] mif = '0;

  always #5 clk = ~clk;

  mfx_unit #(.FieldW(FieldW)) u_dut (
    .clk(clk), .rst(rst), .accValid(accValid), .accKind(accKind),
    .accWrite(accWrite), .cpuAddr(cpuAddr), .wrData(wrData),
    .jumpTaken(jumpTaken), .physAddr(physAddr), .memEn(memEn), .ioSel(ioSel)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive, check combinational outputs, then clock and update model
  task automatic cyc(input logic v, input logic [1:0] k, input logic w,
                     input logic [11:0] a, input logic [11:0] d, input logic j,
                     input string tag);
    logic expIo, expMem;
    logic [FieldW-1:0] bank, nd;
    @(negedge clk);
    accValid = v; accKind = k; accWrite = w; cpuAddr = a; wrData = d; jumpTaken = j;
    #1;
    expIo  = v && (a == 12'hFFF);
    expMem = v && !expIo;
    check(ioSel == expIo, {tag, " R8/R9 ioSel"}, ioSel, expIo);
    check(memEn == expMem, {tag, " R8/R9 memEn"}, memEn, expMem);
    if (expMem) begin
      bank = (k == 2'd2) ? mdf : mif;
      check(physAddr == {bank, a}, {tag, " physAddr"}, physAddr, {bank, a});
    end
    @(posedge clk);
    nd = mdf;
    if (v && w && (k == 2'd2 || k == 2'd3) && a == 12'hFFF && d[11:8] == 4'hC)
      nd = d[FieldW-1:0];
    if (j) mif = mdf;
    mdf = nd;
  endtask

  task automatic setDf(input int val);
    cyc(1, 2'd3, 1, 12'hFFF, 12'hC00 | 12'(val), 0, "R4 store");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: bank 0 after reset
    cyc(1, 2'd0, 0, 12'h123, 0, 0, "R1 fetch");
    cyc(1, 2'd2, 0, 12'h456, 0, 0, "R1 indirect");
    // full sweep over data/code bank pairs
    for (int c = 0; c < 8; c++) begin
      setDf(c);
      cyc(0, 2'd0, 0, 0, 0, 1, "R6 jump");
      for (int d = 0; d < 8; d++) begin
        logic [11:0] a;
        a = 12'((c * 8 + d) * 61) & 12'hFFE;
        setDf(d);
        cyc(1, 2'd2, 0, a, 0, 0, "R3 indirect");
        cyc(1, 2'd2, 1, a ^ 12'h0F0, 0, 0, "R3 indirect store");
        cyc(1, 2'd3, 0, a, 0, 0, "R2 direct");
        cyc(1, 2'd1, 0, a, 0, 0, "R2 pointer");
        cyc(1, 2'd0, 0, a, 0, 0, "R7 fetch no jump");
        cyc(1, 2'd2, 0, 12'hFFF, 0, 0, "R8 io read");
      end
    end
    // R6: jump during a fetch cycle, new bank at target fetch
    setDf(5);
    cyc(1, 2'd0, 0, 12'h010, 0, 1, "R6 jump fetch");
    cyc(1, 2'd0, 0, 12'h200, 0, 0, "R6 target fetch");
    cyc(1, 2'd2, 0, 12'h201, 0, 0, "R6 df kept");
    // R5: non-setting writes
    setDf(2);
    cyc(1, 2'd3, 1, 12'hFFF, 12'h805, 0, "R5 i2c write");
    cyc(1, 2'd2, 0, 12'h033, 0, 0, "R5 after i2c");
    cyc(1, 2'd2, 1, 12'hFFF, 12'h107, 0, "R5 lcd write");
    cyc(1, 2'd2, 0, 12'h034, 0, 0, "R5 after lcd");
    cyc(1, 2'd3, 1, 12'h7FF, 12'hC06, 0, "R5 other addr");
    cyc(1, 2'd2, 0, 12'h035, 0, 0, "R5 after other");
    cyc(1, 2'd3, 0, 12'hFFF, 12'hC04, 0, "R5 io read");
    cyc(1, 2'd2, 0, 12'h036, 0, 0, "R5 after read");
    check(mdf == 3'd2, "R5 model df", mdf, 2);
    // R9: idle cycles
    cyc(0, 2'd2, 1, 12'hFFF, 12'hC07, 0, "R9 idle");
    cyc(1, 2'd2, 0, 12'h037, 0, 0, "R9 after idle");
    // R1 again: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    @(negedge clk); rst = 1'b0; mdf = '0; mif = '0;
    cyc(1, 2'd0, 0, 12'h100, 0, 0, "R1 fetch after reset");
    cyc(1, 2'd2, 0, 12'h101, 0, 0, "R1 indirect after reset");
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule